// File: doc/BRIEF.md
# Blanked Biased Current Accumulator

This block keeps a running signed sum of current samples for a battery charge counter. Each sample first has a signed offset correction added. The corrected value then passes a blanking stage that forces small readings to zero, so that noise near zero does not drift the count. Small positive (charge) readings are always blanked. Small negative (discharge) readings are blanked only when a separate enable is set, and the threshold for negative readings is lower than the threshold for positive ones.

After blanking, a programmable signed accumulation bias is added on every sample, whether or not the current was blanked. This lets firmware account for standby drain that is too small to measure. The result is added to the stored total.

The total can be read at any time. The host interface can overwrite it, and a host load wins over an accumulate that falls in the same cycle. The total saturates at its signed limits instead of wrapping. A variant with wrapping arithmetic can be chosen through a parameter.

Top module: `curacc_top`

## Requirements
- R1: After an active-low reset the accumulator output reads 0.
- R2: The blanking test acts on the corrected value, which is the raw sample plus the sign-extended offset bias, and not on the raw sample alone.
- R3: A corrected value from 1 to POS_THR-1 (default 63) is replaced by 0 before accumulation, whatever the enable. A value of POS_THR (64) or more is kept.
- R4: A corrected value from -(NEG_THR-1) to -1 (default -15 to -1) is replaced by 0 only when neg_blank_en is 1. A value of -NEG_THR (-16) or below is always kept, and with neg_blank_en at 0 every negative value is kept.
- R5: On a cycle with smp_vld high, the new total is the previous total plus the blanked current plus the signed 8-bit accumulation bias. The total is visible on acc_out one clock edge later.
- R6: The accumulation bias is added even when the current is blanked to zero.
- R7: A new accumulation bias value applies from the first sample taken after it changes.
- R8: With SATURATE=1 (default), the total clamps at +32767 and -32768 instead of wrapping.
- R9: When host_ld is high, the total becomes host_data at the next edge, even if smp_vld is also high.
- R10: With smp_vld and host_ld both low, the total does not change, whatever the sample inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | A new current sample is present this cycle |
| smp_cur | input | CUR_W (16) | Raw signed current sample |
| ofs_bias | input | OFS_W (8) | Signed offset correction added before blanking |
| acc_bias | input | BIAS_W (8) | Signed bias added after blanking |
| neg_blank_en | input | 1 | Enables blanking of small negative values |
| host_ld | input | 1 | Load the total from host_data |
| host_data | input | ACC_W (16) | Value to load |
| acc_out | output | ACC_W (16) | Accumulated total |

## Verification
The bench drives values at the exact edges of each blanking window: 63 and 64 on the charge side, and -15 and -16 on the discharge side, with the enable both off and on. A design with an off-by-one compare or with the enable ignored would then count a reading it should have dropped, or drop one it should have kept.

Offset-corrected pairs are chosen so that the raw sample and the corrected value fall on opposite sides of a threshold, which exposes a design that tests the raw sample. A blanked sample with a nonzero bias shows whether the bias is wrongly gated by the blanking stage.

Runs near both limits show whether the total wraps. A load issued during a valid sample shows whether the load really has priority.

// File: rtl/curacc_pkg.sv
package curacc_pkg;
   // Clamp a wide signed sum into a narrower signed range
   function automatic logic signed [63:0] clamp_s(input logic signed [63:0] v,
                                                  input int unsigned      w);
      logic signed [63:0] hi;
      logic signed [63:0] lo;
      hi = (64'sd1 <<< (w - 1)) - 64'sd1;
      lo = -(64'sd1 <<< (w - 1));
      if (v > hi)      return hi;
      else if (v < lo) return lo;
      else             return v;
   endfunction
endpackage

// File: rtl/curacc_blank.sv
module curacc_blank #(
   parameter int CUR_W   = 16,
   parameter int OFS_W   = 8,
   parameter int POS_THR = 64,
   parameter int NEG_THR = 16,
   localparam int CW     = ((CUR_W > OFS_W) ? CUR_W : OFS_W) + 1
) (
   input  logic signed [CUR_W-1:0] raw_cur,
   input  logic signed [OFS_W-1:0] ofs,
   input  logic                    neg_en,
   output logic signed [CW-1:0]    blk_cur
);
   localparam logic signed [CW-1:0] POS_T = CW'(POS_THR);
   localparam logic signed [CW-1:0] NEG_T = -CW'(NEG_THR);

   logic signed [CW-1:0] corr;
   logic                 pos_hit;
   logic                 neg_hit;

   always_comb begin
      corr    = CW'(raw_cur) + CW'(ofs);
      pos_hit = (corr > 0) && (corr < POS_T);
      neg_hit = neg_en && (corr < 0) && (corr > NEG_T);
      blk_cur = (pos_hit || neg_hit) ? '0 : corr;
   end

   // R3
   always_comb begin
      pos_window_chk: assert (!((blk_cur > 0) && (blk_cur < POS_T)));
   end

   // R4
   always_comb begin
      neg_window_chk: assert (!(neg_en && (blk_cur < 0) && (blk_cur > NEG_T)));
   end
endmodule

// File: rtl/curacc_sum.sv
module curacc_sum #(
   parameter int IN_W     = 17,
   parameter int BIAS_W   = 8,
   parameter int ACC_W    = 16,
   parameter bit SATURATE = 1'b1,
   localparam int SW      = ((IN_W > ACC_W) ? IN_W : ACC_W) + 2
) (
   input  logic signed [IN_W-1:0]   cur,
   input  logic signed [BIAS_W-1:0] bias,
   input  logic signed [ACC_W-1:0]  prev,
   output logic signed [ACC_W-1:0]  next
);
   import curacc_pkg::*;

   logic signed [SW-1:0] wide;

   always_comb begin
      wide = SW'(cur) + SW'(bias) + SW'(prev);
   end

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            next = ACC_W'(clamp_s(64'(wide), ACC_W));
         end
      end else begin : g_wrap
         always_comb begin
            next = wide[ACC_W-1:0];
         end
      end
   endgenerate
endmodule

// File: rtl/curacc_top.sv
module curacc_top #(
   parameter int CUR_W    = 16,
   parameter int OFS_W    = 8,
   parameter int BIAS_W   = 8,
   parameter int ACC_W    = 16,
   parameter int POS_THR  = 64,
   parameter int NEG_THR  = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_vld,
   input  logic [CUR_W-1:0]  smp_cur,
   input  logic [OFS_W-1:0]  ofs_bias,
   input  logic [BIAS_W-1:0] acc_bias,
   input  logic              neg_blank_en,
   input  logic              host_ld,
   input  logic [ACC_W-1:0]  host_data,
   output logic [ACC_W-1:0]  acc_out
);
   localparam int CW = ((CUR_W > OFS_W) ? CUR_W : OFS_W) + 1;

   generate
      if (POS_THR < 1 || NEG_THR < 1) begin : g_bad_thr
         $error("curacc_top: thresholds must be at least 1");
      end
      if (ACC_W < 2 || ACC_W > 62 || BIAS_W > ACC_W) begin : g_bad_w
         $error("curacc_top: accumulator width out of range");
      end
   endgenerate

   logic signed [CW-1:0]    blk_cur;
   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W-1:0] acc_nx;
   logic                    incr_nonneg;

   curacc_blank #(
      .CUR_W  (CUR_W),
      .OFS_W  (OFS_W),
      .POS_THR(POS_THR),
      .NEG_THR(NEG_THR)
   ) u_blank (
      .raw_cur(smp_cur),
      .ofs    (ofs_bias),
      .neg_en (neg_blank_en),
      .blk_cur(blk_cur)
   );

   curacc_sum #(
      .IN_W    (CW),
      .BIAS_W  (BIAS_W),
      .ACC_W   (ACC_W),
      .SATURATE(SATURATE)
   ) u_sum (
      .cur (blk_cur),
      .bias(acc_bias),
      .prev(acc_q),
      .next(acc_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       acc_q <= '0;
      else if (host_ld) acc_q <= host_data;
      else if (smp_vld) acc_q <= acc_nx;
   end

   assign acc_out = acc_q;

   always_comb begin
      incr_nonneg = ((CW + 1)'(blk_cur) + (CW + 1)'($signed(acc_bias))) >= 0;
   end

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_vld && !host_ld) |=> $stable(acc_out));

   // R9
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_ld |=> (acc_out == $past(host_data)));

   // R8
   generate
      if (SATURATE) begin : g_sat_chk
         no_wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_vld && !host_ld && incr_nonneg) |=> ($signed(acc_out) >= $past(acc_q)));
         no_wrap_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_vld && !host_ld && !incr_nonneg) |=> ($signed(acc_out) < $past(acc_q)
                                                      || $past(acc_q) == -(2 ** (ACC_W - 1))));
      end
   endgenerate
endmodule

// File: tb/tb_curacc_top.sv
module tb_curacc_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_vld = 1'b0;
   logic [15:0] smp_cur = '0;
   logic [7:0]  ofs_bias = '0;
   logic [7:0]  acc_bias = '0;
   logic        neg_blank_en = 1'b0;
   logic        host_ld = 1'b0;
   logic [15:0] host_data = '0;
   logic [15:0] acc_out;

   int total = 0;
   int bad = 0;
   int expv = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   curacc_top dut (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_cur(smp_cur),
      .ofs_bias(ofs_bias), .acc_bias(acc_bias), .neg_blank_en(neg_blank_en),
      .host_ld(host_ld), .host_data(host_data), .acc_out(acc_out)
   );

   function automatic int model(int prev, int raw, int ofs, int bias, bit en);
      int c;
      int s;
      c = raw + ofs;
      if (c > 0 && c < 64) c = 0;
      if (en && c < 0 && c > -16) c = 0;
      s = prev + c + bias;
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      return s;
   endfunction

   task automatic check(string req, int expd);
      int act;
      act = int'($signed(acc_out));
      total++;
      if (act !== expd) begin
         bad++;
         $display("FAIL %s: acc_out=%0d expected=%0d", req, act, expd);
      end
   endtask

   task automatic sample(string req, int raw, int ofs, int bias, bit en);
      smp_cur = 16'(raw);
      ofs_bias = 8'(ofs);
      acc_bias = 8'(bias);
      neg_blank_en = en;
      smp_vld = 1'b1;
      @(negedge clk);
      smp_vld = 1'b0;
      expv = model(expv, raw, ofs, bias, en);
      check(req, expv);
   endtask

   task automatic load(string req, int val, bit with_smp);
      host_data = 16'(val);
      host_ld = 1'b1;
      smp_vld = with_smp;
      smp_cur = 16'(1000);
      @(negedge clk);
      host_ld = 1'b0;
      smp_vld = 1'b0;
      expv = val;
      check(req, expv);
   endtask

   task automatic t_reset();
      check("R1", 0);
   endtask

   task automatic t_pos_window();
      sample("R3", 63, 0, 0, 1'b0);
      sample("R3", 64, 0, 0, 1'b0);
      sample("R3", 1, 0, 0, 1'b1);
   endtask

   task automatic t_neg_window();
      sample("R4", -15, 0, 0, 1'b0);
      sample("R4", -15, 0, 0, 1'b1);
      sample("R4", -16, 0, 0, 1'b1);
      sample("R4", -1, 0, 0, 1'b0);
   endtask

   task automatic t_offset();
      sample("R2", 70, -10, 0, 1'b0);
      sample("R2", 60, 10, 0, 1'b0);
      sample("R2", -20, 5, 0, 1'b1);
   endtask

   task automatic t_bias();
      sample("R5", 200, 0, 5, 1'b0);
      sample("R6", 10, 0, 3, 1'b0);
      sample("R6", -5, 0, -7, 1'b1);
      sample("R7", 100, 0, -128, 1'b0);
      sample("R7", 0, 0, 127, 1'b0);
   endtask

   task automatic t_idle();
      smp_cur = 16'(1000);
      acc_bias = 8'(50);
      ofs_bias = 8'(20);
      repeat (3) @(negedge clk);
      check("R10", expv);
   endtask

   task automatic t_load();
      load("R9", 500, 1'b1);
      load("R9", -1234, 1'b0);
   endtask

   task automatic t_sat();
      load("R8", 32760, 1'b0);
      sample("R8", 100, 0, 0, 1'b0);
      check("R8", 32767);
      sample("R8", 100, 0, 127, 1'b0);
      load("R8", -32760, 1'b0);
      sample("R8", -100, 0, 0, 1'b0);
      check("R8", -32768);
      sample("R8", 0, 0, -128, 1'b0);
      sample("R8", 300, 0, 0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pos_window();
      t_neg_window();
      t_offset();
      t_bias();
      t_idle();
      t_load();
      t_sat();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog: run did not end, expected completion");
         end
      join_any
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule